// File: doc/BRIEF.md
# Exception Vector and Return-Address Unit

This unit sits where instructions retire in a simple in-order processor. In each retirement slot it gathers every pending event and picks one. The candidate events are instruction faults, instruction traps, aborts, a software interrupt instruction, a non-maskable interrupt and a maskable interrupt. For the chosen event it registers four things: the 8-bit vector, a class code, the return address the handler must save, and a flag that says whether that address can be used to restart. It then raises a one-cycle pulse toward fetch.

The class of an event decides the return address:

- A fault stops the instruction in the slot from committing. Its return address is that instruction's first byte, prefixes included.
- Traps and interrupts let the instruction finish. Their return address is the instruction that follows.
- Aborts have no precise location and are marked as not restartable.

After a take, the unit waits for an acknowledge before it accepts anything new. A fault that arrives during that wait is turned into a double-fault abort.

Top module: `exc_vector_unit`

## Requirements
- R1: In a retire cycle, with no abort pending and the unit idle, any valid fault bit leads to a take one cycle later. The take carries class 0 (fault), the lowest pending fault vector, ret_addr equal to the sampled cur_pc, and ret_ok=1. Valid fault vectors are 0, 1, 5, 6, 7, 10–14 and 16, where bit v of flt_req requests vector v. Vector 1 in this path is the debug fault that applies to the current instruction.
- R2: When no abort or fault is pending, a valid trap bit leads to a take with class 1 (trap), the lowest pending trap vector, ret_addr equal to the sampled next_pc, and ret_ok=1. Valid trap vectors are 1 (debug trap), 3 (breakpoint) and 4 (overflow), where bit v of trp_req requests vector v.
- R3: abt_req[0] requests vector 8 and abt_req[1] requests vector 9. Bit 0 wins over bit 1, and either wins over every other event. Such a take has class 2 (abort), ret_ok=0 and ret_addr=0.
- R4: A software interrupt request with swi_vec between 33 and 255 is taken as class 1 with that vector and ret_addr=next_pc. Its priority is just below the fixed traps. A request with swi_vec below 33 is ignored.
- R5: Fault bits 2, 3, 4, 8, 9 and 15, and trap bits 0 and 2, are ignored. The reserved vectors 15 and 17–32 are never emitted for classes 0–2.
- R6: The priority order is abort, then fault, then trap, then software interrupt, then NMI, then maskable interrupt.
- R7: The maskable interrupt is taken only while if_en=1. It is taken as class 3 with vector intr_vec and ret_addr=next_pc.
- R8: The NMI is taken as class 3 with vector 2 and ret_addr=next_pc. Once it has been taken, nmi is ignored until a nmi_ret pulse arrives.
- R9: take is high for one cycle, in the cycle after the retire slot. With retire low, nothing is taken. After a take, events are ignored until ack is seen. vec, cls, ret_addr and ret_ok hold until the next take.
- R10: A valid fault in a retire cycle while the unit is waiting for ack produces a take of vector 8, class 2, ret_ok=0. The unit keeps waiting for ack.
- R11: kill is a combinational output. It is high in any retire cycle with a valid fault bit.
- R12: After reset, take, vec, cls, ret_addr, ret_ok are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire | input | 1 | Retirement slot valid |
| flt_req | input | 17 | Fault requests, bit v = vector v |
| trp_req | input | 5 | Trap requests, bit v = vector v |
| abt_req | input | 2 | Abort requests (bit0 vector 8, bit1 vector 9) |
| swi_req | input | 1 | Software interrupt instruction retiring |
| swi_vec | input | 8 | Immediate vector of the software interrupt |
| nmi | input | 1 | Non-maskable interrupt request |
| nmi_ret | input | 1 | Return-from-NMI strobe |
| intr | input | 1 | Maskable interrupt request |
| if_en | input | 1 | Maskable interrupt enable |
| intr_vec | input | 8 | Vector supplied with the maskable interrupt |
| cur_pc | input | AW | Start of retiring instruction, prefixes included |
| next_pc | input | AW | Address of the following instruction |
| ack | input | 1 | Delivery acknowledge |
| take | output | 1 | One-cycle exception-taken pulse |
| vec | output | 8 | Vector number |
| cls | output | 2 | Class: 0 fault, 1 trap, 2 abort, 3 interrupt |
| ret_addr | output | AW | Return address to save |
| ret_ok | output | 1 | Return address is restartable |
| kill | output | 1 | Block commit of retiring instruction |

## Verification
The two state bits inside the unit are the wait-for-ack flag and the NMI block. Either one being wrong shows at the ports on the very next retire cycle:

- A take appears that should have been held off, or an expected take is missing.
- A fault that should have escalated comes out with its own vector.
- A second NMI is taken without an nmi_ret in between.

A wrong selection shows in vec, cls or ret_addr one cycle after the slot. The bench compares these outputs against its own model on every clock.

// File: rtl/exc_vector_unit.sv
module exc_vector_unit #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          retire,
  input  logic [16:0]   flt_req,
  input  logic [4:0]    trp_req,
  input  logic [1:0]    abt_req,
  input  logic          swi_req,
  input  logic [7:0]    swi_vec,
  input  logic          nmi,
  input  logic          nmi_ret,
  input  logic          intr,
  input  logic          if_en,
  input  logic [7:0]    intr_vec,
  input  logic [AW-1:0] cur_pc,
  input  logic [AW-1:0] next_pc,
  input  logic          ack,
  output logic          take,
  output logic [7:0]    vec,
  output logic [1:0]    cls,
  output logic [AW-1:0] ret_addr,
  output logic          ret_ok,
  output logic          kill
);
  localparam logic [16:0] FLT_OK = 17'h17CE3;
  localparam logic [4:0]  TRP_OK = 5'b11010;
  localparam logic [1:0]  C_FLT = 2'd0, C_TRP = 2'd1, C_ABT = 2'd2, C_INT = 2'd3;

  logic          busy, nmi_blk;
  logic [16:0]   flt;
  logic [4:0]    trp;
  logic [1:0]    abt;
  logic          swi_ok, nmi_ok, intr_ok;
  logic          hit, pick_nmi;
  logic [7:0]    s_vec;
  logic [1:0]    s_cls;
  logic [AW-1:0] s_ret;
  logic          s_ok;
  logic [7:0]    f_vec, t_vec;

  assign flt     = flt_req & FLT_OK & {17{retire}};
  assign trp     = trp_req & TRP_OK & {5{retire}};
  assign abt     = abt_req & {2{retire}};
  assign swi_ok  = retire & swi_req & (swi_vec >= 8'd33);
  assign nmi_ok  = retire & nmi & ~nmi_blk;
  assign intr_ok = retire & intr & if_en;
  assign kill    = |flt;

  always_comb begin
    f_vec = '0;
    t_vec = '0;
    for (int i = 16; i >= 0; i--) if (flt[i]) f_vec = 8'(i);
    for (int i = 4; i >= 0; i--)  if (trp[i]) t_vec = 8'(i);
  end

  always_comb begin
    hit      = 1'b1;
    pick_nmi = 1'b0;
    s_vec    = '0;
    s_cls    = C_FLT;
    s_ret    = next_pc;
    s_ok     = 1'b1;
    if (|abt) begin
      s_vec = abt[0] ? 8'd8 : 8'd9;
      s_cls = C_ABT;
      s_ret = '0;
      s_ok  = 1'b0;
    end else if (|flt) begin
      s_vec = f_vec;
      s_ret = cur_pc;
    end else if (|trp) begin
      s_vec = t_vec;
      s_cls = C_TRP;
    end else if (swi_ok) begin
      s_vec = swi_vec;
      s_cls = C_TRP;
    end else if (nmi_ok) begin
      s_vec    = 8'd2;
      s_cls    = C_INT;
      pick_nmi = 1'b1;
    end else if (intr_ok) begin
      s_vec = intr_vec;
      s_cls = C_INT;
    end else begin
      hit = 1'b0;
    end
  end

  wire go  = ~busy & hit;
  wire esc = busy & (|flt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take     <= 1'b0;
      vec      <= '0;
      cls      <= C_FLT;
      ret_addr <= '0;
      ret_ok   <= 1'b0;
      busy     <= 1'b0;
      nmi_blk  <= 1'b0;
    end else begin
      take    <= go | esc;
      busy    <= go | esc | (busy & ~ack);
      nmi_blk <= (go & pick_nmi) | (nmi_blk & ~nmi_ret);
      if (esc) begin
        vec      <= 8'd8;
        cls      <= C_ABT;
        ret_addr <= '0;
        ret_ok   <= 1'b0;
      end else if (go) begin
        vec      <= s_vec;
        cls      <= s_cls;
        ret_addr <= s_ret;
        ret_ok   <= s_ok;
      end
    end
  end
endmodule

// File: rtl/exc_vector_unit_chk.sv
module exc_vector_unit_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          retire,
  input logic          nmi,
  input logic          intr,
  input logic          if_en,
  input logic [AW-1:0] cur_pc,
  input logic [AW-1:0] next_pc,
  input logic          take,
  input logic [7:0]    vec,
  input logic [1:0]    cls,
  input logic [AW-1:0] ret_addr,
  input logic          ret_ok
);
  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!take || (cls == 2'd2 && vec == 8'd8)));

  a_r9_needs_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !retire |=> !take);

  a_r1_fault_ret: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cls == 2'd0) |-> (ret_addr == $past(cur_pc) && ret_ok));

  a_r2_trap_ret: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cls == 2'd1) |-> (ret_addr == $past(next_pc) && ret_ok));

  a_r3_abort_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cls == 2'd2) |-> (!ret_ok && ret_addr == '0));

  a_r5_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cls != 2'd3) |-> !(vec == 8'd15 || (vec >= 8'd17 && vec <= 8'd32)));

  a_r7_intr_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cls == 2'd3 && !$past(nmi)) |-> ($past(intr) && $past(if_en)));
endmodule

bind exc_vector_unit exc_vector_unit_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .retire(retire), .nmi(nmi), .intr(intr), .if_en(if_en),
  .cur_pc(cur_pc), .next_pc(next_pc), .take(take), .vec(vec), .cls(cls),
  .ret_addr(ret_addr), .ret_ok(ret_ok)
);

// File: tb/test_exc_vector_unit.sv
module test_exc_vector_unit;
  localparam int AW = 32;
  logic clk = 0, rst_n = 0, retire = 0, swi_req = 0, nmi = 0, nmi_ret = 0;
  logic intr = 0, if_en = 0, ack = 0;
  logic [16:0] flt_req = '0;
  logic [4:0]  trp_req = '0;
  logic [1:0]  abt_req = '0;
  logic [7:0]  swi_vec = '0, intr_vec = '0;
  logic [AW-1:0] cur_pc = '0, next_pc = '0;
  logic take, ret_ok, kill;
  logic [7:0] vec;
  logic [1:0] cls;
  logic [AW-1:0] ret_addr;

  int checks = 0, fails = 0;
  string req = "R12";

  always #2 clk = ~clk;

  exc_vector_unit #(.AW(AW)) i_exc_vector_unit (
    .clk(clk), .rst_n(rst_n), .retire(retire), .flt_req(flt_req), .trp_req(trp_req),
    .abt_req(abt_req), .swi_req(swi_req), .swi_vec(swi_vec), .nmi(nmi), .nmi_ret(nmi_ret),
    .intr(intr), .if_en(if_en), .intr_vec(intr_vec), .cur_pc(cur_pc), .next_pc(next_pc),
    .ack(ack), .take(take), .vec(vec), .cls(cls), .ret_addr(ret_addr), .ret_ok(ret_ok),
    .kill(kill));

  function automatic bit is_fault(int v);
    return v inside {0, 1, 5, 6, 7, [10:14], 16};
  endfunction
  function automatic bit is_trap(int v);
    return v inside {1, 3, 4};
  endfunction
  function automatic int low_fault();
    for (int v = 0; v <= 16; v++) if (retire && flt_req[v] && is_fault(v)) return v;
    return -1;
  endfunction

  // reference model
  logic m_take = 0, m_ok = 0, m_busy = 0, m_nblk = 0;
  logic [7:0] m_vec = 0;
  logic [1:0] m_cls = 0;
  logic [AW-1:0] m_ret = 0;

  always @(posedge clk) begin
    int fv, tv, ev_vec, ev_cls;
    logic ev_ok;
    logic [AW-1:0] ev_ret;
    if (!rst_n) begin
      m_take <= 0; m_vec <= 0; m_cls <= 0; m_ret <= 0; m_ok <= 0; m_busy <= 0; m_nblk <= 0;
    end else begin
      fv = low_fault();
      tv = -1;
      for (int v = 4; v >= 0; v--) if (retire && trp_req[v] && is_trap(v)) tv = v;
      ev_vec = -1; ev_cls = 0; ev_ok = 1; ev_ret = next_pc;
      m_take <= 0;
      if (nmi_ret) m_nblk <= 0;
      if (m_busy) begin
        if (fv >= 0) begin
          m_take <= 1; m_vec <= 8; m_cls <= 2; m_ret <= 0; m_ok <= 0;
        end else if (ack) m_busy <= 0;
      end else if (retire) begin
        if (abt_req != 0) begin ev_vec = abt_req[0] ? 8 : 9; ev_cls = 2; ev_ok = 0; ev_ret = 0; end
        else if (fv >= 0) begin ev_vec = fv; ev_cls = 0; ev_ret = cur_pc; end
        else if (tv >= 0) begin ev_vec = tv; ev_cls = 1; end
        else if (swi_req && swi_vec >= 33) begin ev_vec = swi_vec; ev_cls = 1; end
        else if (nmi && !m_nblk) begin ev_vec = 2; ev_cls = 3; m_nblk <= 1; end
        else if (intr && if_en) begin ev_vec = intr_vec; ev_cls = 3; end
        if (ev_vec >= 0) begin
          m_take <= 1; m_busy <= 1; m_vec <= 8'(ev_vec); m_cls <= 2'(ev_cls);
          m_ret <= ev_ret; m_ok <= ev_ok;
        end
      end
    end
  end

  task automatic tick();
    #1;
    checks++;
    if (kill !== (low_fault() >= 0)) begin
      fails++;
      $display("FAIL %s (R11): kill=%b expected %b", req, kill, low_fault() >= 0);
    end
    @(posedge clk);
    #1;
    checks++;
    if (take !== m_take || vec !== m_vec || cls !== m_cls || ret_addr !== m_ret || ret_ok !== m_ok) begin
      fails++;
      $display("FAIL %s: take=%b vec=%0d cls=%0d ret=%h ok=%b expected take=%b vec=%0d cls=%0d ret=%h ok=%b",
               req, take, vec, cls, ret_addr, ret_ok, m_take, m_vec, m_cls, m_ret, m_ok);
    end
  endtask

  task automatic clr();
    retire = 0; flt_req = 0; trp_req = 0; abt_req = 0; swi_req = 0; swi_vec = 0;
    nmi = 0; nmi_ret = 0; intr = 0; ack = 0;
  endtask

  task automatic slot(string r, logic [AW-1:0] pc);
    req = r; retire = 1; cur_pc = pc; next_pc = pc + 5;
    tick(); clr(); tick(); ack = 1; tick(); ack = 0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    req = "R12"; tick();

    flt_req[13] = 1; flt_req[6] = 1; slot("R1", 32'h1000);
    flt_req[1] = 1;  slot("R1", 32'h1010);
    flt_req[16] = 1; trp_req[3] = 1; slot("R1", 32'h1020);
    trp_req[4] = 1;  slot("R2", 32'h2000);
    trp_req[1] = 1; trp_req[3] = 1; slot("R2", 32'h2010);
    abt_req = 2'b10; flt_req[0] = 1; slot("R3", 32'h3000);
    abt_req = 2'b11; slot("R3", 32'h3010);
    swi_req = 1; swi_vec = 8'h80; slot("R4", 32'h4000);
    swi_req = 1; swi_vec = 8'd32; slot("R4", 32'h4010);
    swi_req = 1; swi_vec = 8'd33; slot("R4", 32'h4020);
    flt_req[15] = 1; flt_req[3] = 1; flt_req[9] = 1; trp_req[0] = 1; trp_req[2] = 1; slot("R5", 32'h5000);
    flt_req[12] = 1; trp_req[1] = 1; nmi = 1; intr = 1; if_en = 1; intr_vec = 8'h40; slot("R6", 32'h6000);
    trp_req[3] = 1; swi_req = 1; swi_vec = 8'd99; nmi = 1; intr = 1; slot("R6", 32'h6010);
    nmi = 1; intr = 1; slot("R6", 32'h6020);
    nmi = 1; slot("R8", 32'h6030);
    nmi = 1; intr = 1; slot("R8", 32'h6040);
    nmi_ret = 1; req = "R8"; tick(); clr();
    nmi = 1; slot("R8", 32'h6050);
    nmi_ret = 1; tick(); clr();
    if_en = 0; intr = 1; slot("R7", 32'h7000);
    if_en = 1; intr = 1; intr_vec = 8'd17; slot("R7", 32'h7010);
    req = "R9"; flt_req[0] = 1; tick(); clr(); tick();
    trp_req[4] = 1; retire = 1; cur_pc = 32'h9000; next_pc = 32'h9002; tick(); clr();
    trp_req[3] = 1; retire = 1; tick(); clr();
    tick(); ack = 1; tick(); ack = 0;
    trp_req[3] = 1; slot("R9", 32'h9100);
    req = "R10"; trp_req[1] = 1; retire = 1; cur_pc = 32'hA000; next_pc = 32'hA004; tick(); clr();
    flt_req[14] = 1; retire = 1; tick(); clr();
    flt_req[7] = 1; retire = 1; ack = 1; tick(); clr();
    trp_req[4] = 1; retire = 1; tick(); clr();
    ack = 1; tick(); ack = 0;
    trp_req[4] = 1; slot("R10", 32'hA100);
    repeat (2) tick();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule